// File: doc/BRIEF.md
# Floating-Point Data Class Tester

This block inspects one IEEE-754 operand, either binary32 or binary64 as picked by a format input, and answers two questions about it in the same cycle. The first is whether the operand falls in any of the data classes a 12-bit class mask selects. Each class has two mask bits: the operand's own sign decides which of the pair is consulted. The second answer is a four-valued sign/zero code of the kind that load-and-test, absolute-value and negate operations report.

Classification is combinational. A single register stage captures both results when `valid_i` is high and keeps them while it is low. A binary32 operand occupies the low 32 bits of the 64-bit operand input.

Top module: `fp_class_tester`

## Requirements
- R1: A zero (exponent and fraction all zero) tests mask bit 11 when positive and bit 10 when negative.
- R2: A normal number (exponent neither all zeros nor all ones) tests mask bit 9 when positive and bit 8 when negative.
- R3: A subnormal number (exponent zero, fraction non-zero) tests mask bit 7 when positive and bit 6 when negative.
- R4: An infinity (exponent all ones, fraction zero) tests mask bit 5 when positive and bit 4 when negative.
- R5: A quiet NaN (exponent all ones, top fraction bit 1) tests mask bit 3 when positive and bit 2 when negative.
- R6: A signaling NaN (exponent all ones, top fraction bit 0, rest of fraction non-zero) tests mask bit 1 when positive and bit 0 when negative.
- R7: `sz_code_o` is 3 for any NaN, 0 for a zero of either sign, 1 for any other negative value and 2 for any other positive value.
- R8: With `dbl_i` = 1 all 64 bits form a binary64 operand. With `dbl_i` = 0 bits 31:0 form a binary32 operand and bits 63:32 have no effect on either output.
- R9: Exactly one mask bit is tested per operand. `match_o` is 1 when that bit is set and 0 otherwise, whatever the other eleven bits hold.
- R10: Results appear on `match_o` and `sz_code_o` in the cycle after `valid_i` is sampled high, with `valid_o` high in that cycle. When `valid_i` is low, `valid_o` falls in the next cycle and both results hold their values.
- R11: During reset `valid_o`, `match_o` and `sz_code_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand and mask are valid this cycle |
| dbl_i | input | 1 | 1: binary64, 0: binary32 in low half |
| operand_i | input | 64 | Operand bits |
| mask_i | input | 12 | Class mask, two bits per class |
| valid_o | output | 1 | Results updated this cycle |
| match_o | output | 1 | Operand's class bit is set in the mask |
| sz_code_o | output | 2 | Sign/zero code: 0 zero, 1 negative, 2 positive, 3 NaN |

## Verification
The class match and the sign/zero code come from the same operand and are registered in the same cycle, so every applied operand checks both at once. The interesting overlap is where the two use the sign differently. A negative zero must give code 0 while testing mask bit 10. A negative NaN must give code 3 while testing bit 2 or bit 0. The scoreboard pairs each operand with a mask that holds only the operand's own bit, a mask that holds every other bit, and a mask that holds only the opposite-sign partner bit. It judges both outputs together against a model built from the requirements.

// File: rtl/fpct_pkg.sv
package fpct_pkg;
  localparam int MASK_W  = 12;
  localparam int CLASS_N = MASK_W / 2;

  // order fixes mask position: class k tests bit MASK_W-1-2k (+) / MASK_W-2-2k (-)
  typedef enum logic [2:0] {
    K_ZERO = 3'd0,
    K_NORM = 3'd1,
    K_SUB  = 3'd2,
    K_INF  = 3'd3,
    K_QNAN = 3'd4,
    K_SNAN = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    SZ_ZERO = 2'd0,
    SZ_NEG  = 2'd1,
    SZ_POS  = 2'd2,
    SZ_NAN  = 2'd3
  } sz_e;

  typedef struct packed {
    logic exp_zero;
    logic exp_ones;
    logic frac_zero;
    logic frac_top;
  } fields_t;
endpackage

// File: rtl/fpct_unpack.sv
module fpct_unpack
  import fpct_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] bits_i,
  output logic                  sign_o,
  output fields_t               fields_o
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_w;
  logic [FRAC_W-1:0] frac_w;

  assign sign_o = bits_i[W-1];
  assign exp_w  = bits_i[W-2 -: EXP_W];
  assign frac_w = bits_i[FRAC_W-1:0];

  always_comb begin
    fields_o.exp_zero  = ~|exp_w;
    fields_o.exp_ones  = &exp_w;
    fields_o.frac_zero = ~|frac_w;
    fields_o.frac_top  = frac_w[FRAC_W-1];
  end
endmodule

// File: rtl/fpct_classify.sv
module fpct_classify
  import fpct_pkg::*;
(
  input  fields_t              fields_i,
  output logic [CLASS_N-1:0]   kind_oh_o
);
  kind_e kind;

  always_comb begin
    if (fields_i.exp_ones) begin
      if (fields_i.frac_zero)     kind = K_INF;
      else if (fields_i.frac_top) kind = K_QNAN;
      else                        kind = K_SNAN;
    end else if (fields_i.exp_zero) begin
      kind = fields_i.frac_zero ? K_ZERO : K_SUB;
    end else begin
      kind = K_NORM;
    end
  end

  always_comb begin
    kind_oh_o = '0;
    kind_oh_o[kind] = 1'b1;
  end

  // R9: one class per operand
  always_comb begin
    a_r9_one_class: assert ($onehot(kind_oh_o));
  end
endmodule

// File: rtl/fpct_select.sv
module fpct_select
  import fpct_pkg::*;
(
  input  logic [CLASS_N-1:0] kind_oh_i,
  input  logic               sign_i,
  input  logic [MASK_W-1:0]  mask_i,
  output logic               match_o,
  output sz_e                sz_code_o
);
  logic [CLASS_N-1:0] hit;

  for (genvar k = 0; k < CLASS_N; k++) begin : g_cls
    assign hit[k] = kind_oh_i[k] &
                    (sign_i ? mask_i[MASK_W-2-2*k] : mask_i[MASK_W-1-2*k]);
  end

  assign match_o = |hit;

  always_comb begin
    if (kind_oh_i[K_QNAN] | kind_oh_i[K_SNAN]) sz_code_o = SZ_NAN;
    else if (kind_oh_i[K_ZERO])                sz_code_o = SZ_ZERO;
    else if (sign_i)                           sz_code_o = SZ_NEG;
    else                                       sz_code_o = SZ_POS;
  end

  // R9: match only when the mask is non-empty
  always_comb begin
    a_r9_match_needs_mask: assert (!match_o || (mask_i != '0));
  end
endmodule

// File: rtl/fp_class_tester.sv
module fp_class_tester
  import fpct_pkg::*;
#(
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52,
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic                          dbl_i,
  input  logic [DP_EXP_W+DP_FRAC_W:0]   operand_i,
  input  logic [MASK_W-1:0]             mask_i,
  output logic                          valid_o,
  output logic                          match_o,
  output logic [1:0]                    sz_code_o
);
  localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W;
  localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W;

  logic    [1:0] sign_f;
  fields_t [1:0] fields_f;

  for (genvar f = 0; f < 2; f++) begin : g_fmt
    if (f == 0) begin : g_sp
      fpct_unpack #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) i_unpack (
        .bits_i  (operand_i[SP_W-1:0]),
        .sign_o  (sign_f[f]),
        .fields_o(fields_f[f])
      );
    end else begin : g_dp
      fpct_unpack #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) i_unpack (
        .bits_i  (operand_i),
        .sign_o  (sign_f[f]),
        .fields_o(fields_f[f])
      );
    end
  end

  logic               sign_sel;
  fields_t            fields_sel;
  logic [CLASS_N-1:0] kind_oh;
  logic               match_d;
  sz_e                sz_d;

  assign sign_sel   = sign_f[dbl_i];
  assign fields_sel = fields_f[dbl_i];

  fpct_classify i_classify (
    .fields_i (fields_sel),
    .kind_oh_o(kind_oh)
  );

  fpct_select i_select (
    .kind_oh_i(kind_oh),
    .sign_i   (sign_sel),
    .mask_i   (mask_i),
    .match_o  (match_d),
    .sz_code_o(sz_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      match_o   <= 1'b0;
      sz_code_o <= SZ_ZERO;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        match_o   <= match_d;
        sz_code_o <= sz_d;
      end
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r10_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(match_o) && $stable(sz_code_o)));

  a_r9_empty_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_i == '0) |=> !match_o);

  a_r9_full_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_i == '1) |=> match_o);

  a_r7_dp_nan_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dbl_i && (&operand_i[DP_W-2 -: DP_EXP_W]) &&
     (|operand_i[DP_FRAC_W-1:0])) |=> (sz_code_o == 2'd3));

  a_r7_dp_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dbl_i && operand_i[DP_W-2:0] == '0) |=> (sz_code_o == 2'd0));
endmodule

// File: tb/test_fp_class_tester.sv
module test_fp_class_tester;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        dbl_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic [11:0] mask_i = '0;
  logic        valid_o, match_o;
  logic [1:0]  sz_code_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit [2:0] q_exp[$];
  string    q_tag[$];
  bit       seen = 0;
  bit [2:0] last_res = '0;

  always #5ns clk = ~clk;

  fp_class_tester i_fp_class_tester (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .dbl_i(dbl_i),
    .operand_i(operand_i), .mask_i(mask_i),
    .valid_o(valid_o), .match_o(match_o), .sz_code_o(sz_code_o)
  );

  // positive-sign mask bit of the operand's class; the negative bit is one lower
  function automatic int class_bit(bit dbl, logic [63:0] op);
    bit s, ez, eo, fz, ft;
    if (dbl) begin
      s = op[63]; ez = (op[62:52] == 0); eo = &op[62:52];
      fz = (op[51:0] == 0); ft = op[51];
    end else begin
      s = op[31]; ez = (op[30:23] == 0); eo = &op[30:23];
      fz = (op[22:0] == 0); ft = op[22];
    end
    if (eo && fz)      class_bit = 5;   // R4
    else if (eo && ft) class_bit = 3;   // R5
    else if (eo)       class_bit = 1;   // R6
    else if (ez && fz) class_bit = 11;  // R1
    else if (ez)       class_bit = 7;   // R3
    else               class_bit = 9;   // R2
    class_bit = class_bit - int'(s);
  endfunction

  function automatic bit [1:0] sz_model(bit dbl, logic [63:0] op);
    int b;
    bit s;
    b = class_bit(dbl, op);
    s = dbl ? op[63] : op[31];
    if (b <= 3)       sz_model = 2'd3;
    else if (b >= 10) sz_model = 2'd0;
    else if (s)       sz_model = 2'd1;
    else              sz_model = 2'd2;
  endfunction

  task automatic check(string tag, bit [2:0] act, bit [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual match=%0d code=%0d, expected match=%0d code=%0d",
               tag, act[2], act[1:0], exp[2], exp[1:0]);
    end
  endtask

  task automatic apply(bit dbl, logic [63:0] op, logic [11:0] m, string tag);
    @(negedge clk);
    valid_i = 1'b1; dbl_i = dbl; operand_i = op; mask_i = m;
    q_exp.push_back({m[class_bit(dbl, op)], sz_model(dbl, op)});
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
    operand_i = 64'h7FF8_0000_0000_0000;
    mask_i = 12'hFFF;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        if (q_exp.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: valid_o with no pending item, actual 1 expected 0");
        end else begin
          bit [2:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          check(t, {match_o, sz_code_o}, e);
          last_res = e;
          seen = 1;
        end
      end else if (seen) begin
        check("R10 hold", {match_o, sz_code_o}, last_res);
      end
    end
  end

  task automatic run_vec(bit dbl, logic [63:0] op, string tag);
    int b;
    b = class_bit(dbl, op);
    apply(dbl, op, 12'(1) << b, tag);
    apply(dbl, op, ~(12'(1) << b), {tag, " R9 others"});
    apply(dbl, op, 12'(1) << (b ^ 1), {tag, " R9 partner"});
  endtask

  initial begin
    logic [63:0] sp_v[12];
    string       sp_t[12];
    logic [63:0] dp_v[10];
    string       dp_t[10];
    sp_v = '{64'h0, 64'h8000_0000, 64'h3F80_0000, 64'hC000_0000,
             64'h1, 64'h8040_0000, 64'h7F80_0000, 64'hFF80_0000,
             64'h7FC0_0000, 64'hFFC0_0001, 64'h7F80_0001, 64'hFFA0_0000};
    sp_t = '{"R1 sp +0", "R1 sp -0", "R2 sp +norm", "R2 sp -norm",
             "R3 sp +sub", "R3 sp -sub", "R4 sp +inf", "R4 sp -inf",
             "R5 sp +qnan", "R5 sp -qnan", "R6 sp +snan", "R6 sp -snan"};
    dp_v = '{64'h0, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
             64'hBFF0_0000_0000_0000, 64'h0000_0000_0000_0001,
             64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
             64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001,
             64'hFFF4_0000_0000_0000};
    dp_t = '{"R1 dp +0", "R1 dp -0", "R2 dp +norm", "R2 dp -norm",
             "R3 dp +sub", "R4 dp +inf", "R4 dp -inf", "R5 dp +qnan",
             "R6 dp +snan", "R6 dp -snan"};

    repeat (3) @(negedge clk);
    check("R11 reset", {valid_o, match_o, sz_code_o[1]}, 3'b000);
    check("R11 reset code", {1'b0, sz_code_o}, 3'b000);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) run_vec(1'b0, sp_v[i], sp_t[i]);
    idle(); idle();
    for (int i = 0; i < 10; i++) run_vec(1'b1, dp_v[i], dp_t[i]);
    idle();

    // R8: upper half ignored for binary32, decisive for binary64
    for (int i = 0; i < 12; i++) begin
      run_vec(1'b0, sp_v[i] | 64'hFFF0_1234_0000_0000, {sp_t[i], " R8 upper junk"});
      if (i % 3 == 0) idle();
    end
    run_vec(1'b1, 64'h0000_0000_3F80_0000, "R8 dp of sp bits");
    apply(1'b0, 64'h7FF8_0000_0000_0000, 12'hFFF, "R8 sp zero under dp nan");
    idle();

    // R7/R9: extreme masks, sweep over every single mask bit
    apply(1'b1, 64'hBFF0_0000_0000_0000, 12'h000, "R9 empty mask");
    apply(1'b1, 64'hBFF0_0000_0000_0000, 12'hFFF, "R9 full mask");
    for (int b = 0; b < 12; b++) begin
      apply(1'b1, 64'hFFF8_0000_0000_0000, 12'(1) << b, "R5 R7 -qnan sweep");
      apply(1'b0, 64'h8000_0001, 12'(1) << b, "R3 R7 -sub sweep");
    end
    idle(); idle(); idle();

    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: %0d results missing, expected 0", q_exp.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule